// File: doc/BRIEF.md
# PTP Frequency Servo (PI Loop with Lock Detection)

This block closes the frequency loop of a PTP follower clock. Each time the time-transfer logic produces a new signed offset between the local clock and the leader (in nanoseconds), it presents the value together with a one-cycle valid strobe and the current log2 sync interval. The servo smooths the offset with a first-order low-pass filter, then applies a proportional-plus-integral law and outputs a signed frequency correction in parts per billion. A local clock uses this correction to trim its rate.

The proportional and integral gains are rescaled by the sync interval, so the loop keeps the same dynamics whether sync arrives sixteen times per second or once every sixteen seconds. A lock flag with asymmetric thresholds reports when the clock has converged. An offset larger than a millisecond is treated as a phase step. The servo resets its loop state so that a separate mechanism can slew or jump the clock.

Top module: `ptp_freq_servo`

## Requirements
- R1: While rst_ni is low and after its release, corr_ppb_o is 0, corr_vld_o is 0 and locked_o is 0 until a measurement is accepted.
- R2: A measurement is accepted on a rising clock edge where meas_vld_i is 1. corr_vld_o is high for exactly one clock, two clock edges after that edge. corr_ppb_o changes only while corr_vld_o is high.
- R3: The filtered offset f starts at 0. On each accepted non-step measurement x it becomes f + ((x - f) >>> 2), where >>> is an arithmetic shift that rounds toward minus infinity.
- R4: For a non-step measurement, corr_ppb_o = clamp(P + I). P = S(f >>> KP_SHIFT), using the newly updated f. I is the integrator after S(f >>> KI_SHIFT) has been added to it and the sum has been saturated. With the defaults, KP_SHIFT = 2 and KI_SHIFT = 5.
- R5: log_interval_i is a signed 8-bit value L, clamped to the range -4..+4. S(v) is v <<< L when L >= 0 and v >>> -L when L < 0. L is sampled with the measurement it accompanies.
- R6: The integrator saturates at +/-LIM_PPB (500000).
- R7: corr_ppb_o is clamped to +/-LIM_PPB (500000).
- R8: When unlocked, locked_o goes to 1 on a measurement whose raw magnitude |x| is strictly below 500. A magnitude of exactly 500 does not lock.
- R9: When locked, locked_o falls only on a measurement with |x| strictly above 5000. Magnitudes up to and including 5000 keep it high. locked_o changes only when corr_vld_o is high.
- R10: A measurement with |x| > 1000000 (a phase step) clears the integrator and the filter, drives corr_ppb_o to 0 and forces locked_o low. A measurement with |x| of exactly 1000000 is handled normally.
- R11: offset_ns_i and log_interval_i have no effect while meas_vld_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| meas_vld_i | input | 1 | Offset measurement strobe |
| offset_ns_i | input | OFS_W (32) | Signed offset to the leader in ns |
| log_interval_i | input | 8 | Signed log2 sync interval |
| corr_ppb_o | output | PPB_W (32) | Signed frequency correction in PPB |
| corr_vld_o | output | 1 | One-cycle pulse when corr_ppb_o is updated |
| locked_o | output | 1 | Lock flag with hysteresis |

## Verification
The bench builds the servo with its default parameters: a 32-bit offset, gain shifts of 2 and 5, and a correction limit of 500000 PPB. With these values, an offset near the step threshold at the largest interval pushes the per-sample integral increment to the limit, so both integrator and output saturation can be reached within a few measurements. Intervals outside -4..+4 drive the clamping. Offsets at 499/500, 5000/5001 and 1000000/1000001 probe each threshold exactly.

// File: rtl/ptp_servo_pkg.sv
package ptp_servo_pkg;
  localparam int WIDE_W = 48;
  typedef logic signed [WIDE_W-1:0] wide_t;
  typedef logic signed [3:0] lgi_t;

  function automatic lgi_t clamp_lgi(input logic signed [7:0] v);
    if (v > 8'sd4) return 4'sd4;
    else if (v < -8'sd4) return -4'sd4;
    else return v[3:0];
  endfunction

  // gain rescale by sync interval
  function automatic wide_t log_shift(input wide_t v, input lgi_t l);
    logic [2:0] amt;
    if (l < 0) begin
      amt = 3'(-l);
      return v >>> amt;
    end else begin
      amt = 3'(l);
      return v <<< amt;
    end
  endfunction

  function automatic wide_t sat(input wide_t v, input wide_t lim);
    if (v > lim) return lim;
    else if (v < -lim) return -lim;
    else return v;
  endfunction
endpackage

// File: rtl/servo_ofs_filter.sv
module servo_ofs_filter
  import ptp_servo_pkg::*;
#(
  parameter int OFS_W   = 32,
  parameter int STEP_NS = 1000000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic signed [OFS_W-1:0] ofs_i,
  input  logic signed [7:0]       lgi_i,
  output logic                    vld_o,
  output logic                    step_o,
  output logic        [OFS_W:0]   mag_o,
  output logic signed [OFS_W-1:0] filt_o,
  output lgi_t                    lgi_o
);
  localparam logic [OFS_W:0] STEP_LIM = (OFS_W+1)'(STEP_NS);

  logic signed [OFS_W:0]   ofs_ext, filt_ext, diff, delta, sum;
  logic        [OFS_W:0]   mag;
  logic signed [OFS_W-1:0] filt_q;
  logic                    is_step;

  always_comb begin
    ofs_ext  = {ofs_i[OFS_W-1], ofs_i};
    filt_ext = {filt_q[OFS_W-1], filt_q};
    mag      = ofs_ext[OFS_W] ? unsigned'(-ofs_ext) : unsigned'(ofs_ext);
    is_step  = mag > STEP_LIM;
    diff     = ofs_ext - filt_ext;
    delta    = diff >>> 2;
    sum      = filt_ext + delta;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= '0;
      vld_o  <= 1'b0;
      step_o <= 1'b0;
      mag_o  <= '0;
      lgi_o  <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        step_o <= is_step;
        mag_o  <= mag;
        lgi_o  <= clamp_lgi(lgi_i);
        filt_q <= is_step ? '0 : sum[OFS_W-1:0];
      end
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/servo_pi_law.sv
module servo_pi_law
  import ptp_servo_pkg::*;
#(
  parameter int OFS_W    = 32,
  parameter int PPB_W    = 32,
  parameter int KP_SHIFT = 2,
  parameter int KI_SHIFT = 5,
  parameter int LIM_PPB  = 500000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic                    step_i,
  input  logic signed [OFS_W-1:0] filt_i,
  input  lgi_t                    lgi_i,
  output logic                    vld_o,
  output logic signed [PPB_W-1:0] ppb_o
);
  localparam wide_t LIM = wide_t'(LIM_PPB);

  wide_t f_w, p_term, i_inc, acc_q, acc_nxt, corr;

  always_comb begin
    f_w     = wide_t'(filt_i);
    p_term  = log_shift(f_w >>> KP_SHIFT, lgi_i);
    i_inc   = log_shift(f_w >>> KI_SHIFT, lgi_i);
    acc_nxt = sat(acc_q + i_inc, LIM);
    corr    = sat(p_term + acc_nxt, LIM);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ppb_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        if (step_i) begin
          acc_q <= '0;
          ppb_o <= '0;
        end else begin
          acc_q <= acc_nxt;
          ppb_o <= PPB_W'(corr);
        end
      end
    end
  end
endmodule

// File: rtl/servo_lock_det.sv
module servo_lock_det #(
  parameter int OFS_W     = 32,
  parameter int LOCK_NS   = 500,
  parameter int UNLOCK_NS = 5000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             step_i,
  input  logic [OFS_W:0]   mag_i,
  output logic             locked_o
);
  localparam logic [OFS_W:0] LOCK_LIM   = (OFS_W+1)'(LOCK_NS);
  localparam logic [OFS_W:0] UNLOCK_LIM = (OFS_W+1)'(UNLOCK_NS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) locked_o <= 1'b0;
    else if (vld_i) begin
      if (step_i) locked_o <= 1'b0;
      else if (!locked_o && mag_i < LOCK_LIM) locked_o <= 1'b1;
      else if (locked_o && mag_i > UNLOCK_LIM) locked_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ptp_freq_servo.sv
module ptp_freq_servo
  import ptp_servo_pkg::*;
#(
  parameter int OFS_W     = 32,
  parameter int PPB_W     = 32,
  parameter int KP_SHIFT  = 2,
  parameter int KI_SHIFT  = 5,
  parameter int LIM_PPB   = 500000,
  parameter int LOCK_NS   = 500,
  parameter int UNLOCK_NS = 5000,
  parameter int STEP_NS   = 1000000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    meas_vld_i,
  input  logic signed [OFS_W-1:0] offset_ns_i,
  input  logic signed [7:0]       log_interval_i,
  output logic signed [PPB_W-1:0] corr_ppb_o,
  output logic                    corr_vld_o,
  output logic                    locked_o
);
  logic                    s1_vld, s1_step;
  logic        [OFS_W:0]   s1_mag;
  logic signed [OFS_W-1:0] s1_filt;
  lgi_t                    s1_lgi;

  servo_ofs_filter #(.OFS_W(OFS_W), .STEP_NS(STEP_NS)) i_filt (
    .clk_i, .rst_ni,
    .vld_i (meas_vld_i),
    .ofs_i (offset_ns_i),
    .lgi_i (log_interval_i),
    .vld_o (s1_vld),
    .step_o(s1_step),
    .mag_o (s1_mag),
    .filt_o(s1_filt),
    .lgi_o (s1_lgi)
  );

  servo_pi_law #(
    .OFS_W(OFS_W), .PPB_W(PPB_W), .KP_SHIFT(KP_SHIFT),
    .KI_SHIFT(KI_SHIFT), .LIM_PPB(LIM_PPB)
  ) i_pi (
    .clk_i, .rst_ni,
    .vld_i (s1_vld),
    .step_i(s1_step),
    .filt_i(s1_filt),
    .lgi_i (s1_lgi),
    .vld_o (corr_vld_o),
    .ppb_o (corr_ppb_o)
  );

  servo_lock_det #(.OFS_W(OFS_W), .LOCK_NS(LOCK_NS), .UNLOCK_NS(UNLOCK_NS)) i_lock (
    .clk_i, .rst_ni,
    .vld_i   (s1_vld),
    .step_i  (s1_step),
    .mag_i   (s1_mag),
    .locked_o(locked_o)
  );
endmodule

// File: rtl/ptp_freq_servo_chk.sv
module ptp_freq_servo_chk #(
  parameter int OFS_W   = 32,
  parameter int PPB_W   = 32,
  parameter int LIM_PPB = 500000,
  parameter int STEP_NS = 1000000
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    meas_vld_i,
  input logic signed [OFS_W-1:0] offset_ns_i,
  input logic signed [PPB_W-1:0] corr_ppb_o,
  input logic                    corr_vld_o,
  input logic                    locked_o
);
  logic [1:0] cyc_q;
  logic       big1_q, big2_q;
  logic [OFS_W:0] mag;

  assign mag = offset_ns_i[OFS_W-1] ? unsigned'(-{offset_ns_i[OFS_W-1], offset_ns_i})
                                    : unsigned'({1'b0, offset_ns_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      big1_q <= 1'b0;
      big2_q <= 1'b0;
    end else begin
      if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
      big1_q <= meas_vld_i && (mag > (OFS_W+1)'(STEP_NS));
      big2_q <= big1_q;
    end
  end

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (corr_vld_o == $past(meas_vld_i, 2)));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !corr_vld_o |-> $stable(corr_ppb_o));

  assert_out_clamp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_ppb_o <= PPB_W'(LIM_PPB)) && (corr_ppb_o >= -PPB_W'(LIM_PPB)));

  assert_lock_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(locked_o) |-> corr_vld_o);

  assert_step_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    big2_q |-> (corr_ppb_o == '0) && !locked_o && corr_vld_o);
endmodule

bind ptp_freq_servo ptp_freq_servo_chk #(
  .OFS_W(OFS_W), .PPB_W(PPB_W), .LIM_PPB(LIM_PPB), .STEP_NS(STEP_NS)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .meas_vld_i (meas_vld_i),
  .offset_ns_i(offset_ns_i),
  .corr_ppb_o (corr_ppb_o),
  .corr_vld_o (corr_vld_o),
  .locked_o   (locked_o)
);

// File: tb/test_ptp_freq_servo.sv
`timescale 1ns/1ps
module test_ptp_freq_servo;
  localparam int KP = 2;
  localparam int KI = 5;
  localparam longint LIM = 500000;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               meas_vld_i = 1'b0;
  logic signed [31:0] offset_ns_i = '0;
  logic signed [7:0]  log_interval_i = '0;
  logic signed [31:0] corr_ppb_o;
  logic               corr_vld_o;
  logic               locked_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  longint m_filt, m_acc, m_corr;
  bit     m_lock;

  ptp_freq_servo i_ptp_freq_servo (.*);

  always #2.5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint shv(input longint v, input int l);
    return (l >= 0) ? (v <<< l) : (v >>> (-l));
  endfunction

  function automatic longint satv(input longint v);
    return (v > LIM) ? LIM : ((v < -LIM) ? -LIM : v);
  endfunction

  function automatic void model(input longint x, input int lgi);
    longint mag = (x < 0) ? -x : x;
    int l = (lgi > 4) ? 4 : ((lgi < -4) ? -4 : lgi);
    if (mag > 1000000) begin
      m_filt = 0; m_acc = 0; m_corr = 0; m_lock = 0;
    end else begin
      m_filt = m_filt + ((x - m_filt) >>> 2);
      m_acc  = satv(m_acc + shv(m_filt >>> KI, l));
      m_corr = satv(shv(m_filt >>> KP, l) + m_acc);
      if (!m_lock && mag < 500) m_lock = 1;
      else if (m_lock && mag > 5000) m_lock = 0;
    end
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    meas_vld_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(corr_ppb_o == 0 && !corr_vld_o && !locked_o, "R1 in reset", corr_ppb_o, 0);
    rst_ni = 1'b1;
    m_filt = 0; m_acc = 0; m_corr = 0; m_lock = 0;
    @(negedge clk_i);
    chk(corr_ppb_o == 0 && !corr_vld_o && !locked_o, "R1 after release", corr_ppb_o, 0);
  endtask

  // assumes being called at a negedge
  task automatic meas(input longint x, input int lgi, input string req);
    meas_vld_i = 1'b1;
    offset_ns_i = 32'(x);
    log_interval_i = 8'(lgi);
    model(x, lgi);
    @(negedge clk_i);
    meas_vld_i = 1'b0;
    offset_ns_i = 32'($urandom);
    log_interval_i = 8'($urandom);
    chk(!corr_vld_o, "R2 no early strobe", corr_vld_o, 0);
    @(negedge clk_i);
    chk(corr_vld_o, "R2 strobe at +2", corr_vld_o, 1);
    chk(longint'(corr_ppb_o) == m_corr, req, corr_ppb_o, m_corr);
    chk(locked_o == m_lock, {req, " lock"}, locked_o, m_lock);
    @(negedge clk_i);
    chk(!corr_vld_o, "R2 single pulse", corr_vld_o, 0);
  endtask

  initial begin
    longint x;
    int l, r;
    longint held;
    void'($urandom(32'd1588));
    do_reset();

    // R3/R4 simple convergence, R8 boundary
    meas(500, 0, "R8 mag 500 no lock");
    chk(!locked_o, "R8 exact 500 stays unlocked", locked_o, 0);
    meas(-499, 0, "R8 mag 499 locks");
    chk(locked_o, "R8 locked at 499", locked_o, 1);
    meas(5000, 0, "R9 mag 5000 holds");
    chk(locked_o, "R9 locked at 5000", locked_o, 1);
    meas(-3000, 0, "R9 between thresholds");
    meas(-5001, 0, "R9 mag 5001 unlocks");
    chk(!locked_o, "R9 unlocked at 5001", locked_o, 0);
    meas(2000, 0, "R9 no relock above 500");

    // R11: inputs wiggle with no strobe
    held = corr_ppb_o;
    for (int i = 0; i < 20; i++) begin
      offset_ns_i = 32'($urandom);
      log_interval_i = 8'($urandom);
      @(negedge clk_i);
      chk(!corr_vld_o && longint'(corr_ppb_o) == held, "R11 ignored without strobe", corr_ppb_o, held);
    end
    meas(1200, 0, "R11 filter state intact");

    // R5 interval scaling incl. clamp
    meas(40000, 3, "R5 interval +3");
    meas(40000, -3, "R5 interval -3");
    meas(40000, 100, "R5 clamp high");
    meas(40000, -128, "R5 clamp low");

    // R10 boundary
    meas(1000000, 0, "R10 exactly 1ms normal");
    chk(corr_ppb_o != 0, "R10 1ms not a step", corr_ppb_o, m_corr);
    meas(-1000001, 0, "R10 step clears");
    chk(corr_ppb_o == 0 && !locked_o, "R10 step output zero", corr_ppb_o, 0);
    meas(100, 0, "R10 filter restarted from zero");

    // R6/R7 saturation
    for (int i = 0; i < 6; i++) meas(900000, 4, "R6 integrator drive");
    chk(corr_ppb_o == 32'sd500000, "R7 positive clamp", corr_ppb_o, 500000);
    meas(-200000, 0, "R6 integrator capped at limit");
    for (int i = 0; i < 6; i++) meas(-900000, 4, "R6 negative drive");
    chk(corr_ppb_o == -32'sd500000, "R7 negative clamp", corr_ppb_o, -500000);

    // random mix
    do_reset();
    for (int i = 0; i < 400; i++) begin
      r = $urandom_range(0, 9);
      case (r)
        0, 1, 2, 3: x = longint'($urandom_range(0, 1200)) - 600;
        4, 5:       x = longint'($urandom_range(0, 12000)) - 6000;
        6, 7:       x = longint'($urandom_range(0, 600000)) - 300000;
        8:          x = longint'($urandom_range(0, 2000000)) - 1000000;
        default:    x = longint'($urandom_range(0, 3000000)) - 1500000;
      endcase
      l = int'($urandom_range(0, 12)) - 6;
      meas(x, l, "R4 random PI");
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 4)) @(negedge clk_i);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule